// File: doc/BRIEF.md
# Serial DAC Register Front End

This block is the digital side of a 20-bit voltage-output converter that is programmed over a framed serial link. A host lowers the frame select, clocks in 24 bits MSB first (one read/write flag, a 3-bit register address, 20 data bits) and raises the select again. The block holds an input register, the converter register that drives the 20-bit code, and a programmable clear code. The block samples every pin on its own system clock, so all serial and control edges are detected internally.

The converter code can move in two ways. If the load strobe is held low during a write, it moves as soon as the frame closes. If the strobe is held high, the write is only staged, and a later falling edge of the strobe moves it. An active-low clear pin forces the code to the clear code and blocks every other load for as long as it is held. A software clear bit does a one-time clear. A software reset bit and the reset pin both return all registers to zero. A read frame selects a register, and the next frame shifts that register out on the serial output.

Top module: `dac_serial_frontend`

## Requirements
- R1: A frame of exactly 24 serial clocks with bit 23 = 0 and address bits 22..20 = 001, written while ld_n is low and clr_n is high, sets dac_code to bits 19..0 once sync_n rises.
- R2: A write to address 001 made while ld_n is high leaves dac_code unchanged. The next falling edge of ld_n, with clr_n high, moves the staged value into dac_code.
- R3: A frame that closes after any number of serial clocks other than 24 changes no register.
- R4: A write to address 011 stores the clear code. While clr_n is low, dac_code equals the clear code.
- R5: While clr_n is low, neither a write nor a falling edge of ld_n changes dac_code. After clr_n returns high, dac_code keeps the clear code until a later load. A value staged while clear was held is moved by the next ld_n falling edge.
- R6: A write to address 010 with data bit 1 set and bit 0 clear copies the clear code into dac_code.
- R7: A write to address 010 with data bit 0 set returns dac_code, the clear code, the staged value and any read selection to zero.
- R8: While rst_n is low, dac_code is zero and frames are ignored. After release, all registers hold zero.
- R9: A read frame (bit 23 = 1) selects the register at its address. During the next frame, sdo presents {1, address, value} MSB first. Each bit is valid before the serial clock falling edge that shifts it. Address 010 reads back zero data. sdo is zero when no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low reset pin |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low, data taken on falling edge |
| sdin | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| sdo | output | 1 | Serial readback data |
| dac_code | output | 20 | Code driven to the converter core |

## Verification
The assertions assume that every edge on sync_n, sclk and ld_n is held for more than one system clock. They also assume a serial clock falling edge never lands in the same sampled cycle as a frame-select edge, so shifting and frame start never collide. The bench meets these assumptions by holding each level for at least two clocks and by placing three idle clocks between a frame-select edge and the first serial clock edge. The sweeps cover one-hot and dense codes, every frame length from 0 to 30, and clear, staged load and readback across several clear codes.

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend #(
  parameter int DW = 20,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          sclk,
  input  logic          sdin,
  input  logic          ld_n,
  input  logic          clr_n,
  output logic          sdo,
  output logic [DW-1:0] dac_code
);
  localparam int FW = DW + AW + 1;
  localparam int CW = $clog2(FW + 2);
  localparam logic [AW-1:0] A_DAC = AW'(1);
  localparam logic [AW-1:0] A_CTL = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);

  logic sync_q, sync_q2, sclk_q, sclk_q2, sdin_q, ld_q, ld_q2, clr_q;
  logic [FW-1:0] rx, out_sh;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] dac, cc, inreg;
  logic          pend, rd_pend;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rb_val;

  wire sclk_fall = sclk_q2 & ~sclk_q;
  wire sync_fall = sync_q2 & ~sync_q;
  wire sync_rise = ~sync_q2 & sync_q;
  wire ld_fall   = ld_q2 & ~ld_q;

  wire          frame_ok = sync_rise && (bit_cnt == CW'(FW));
  wire          f_rd     = rx[FW-1];
  wire [AW-1:0] fa       = rx[FW-2:DW];
  wire [DW-1:0] fd       = rx[DW-1:0];
  wire          wr_dac   = frame_ok && !f_rd && fa == A_DAC;
  wire          wr_cc    = frame_ok && !f_rd && fa == A_CLR;
  wire          wr_ctl   = frame_ok && !f_rd && fa == A_CTL;
  wire          sw_rst   = wr_ctl && fd[0];
  wire          sw_clr   = wr_ctl && fd[1] && !fd[0];
  wire          direct   = wr_dac && !ld_q && clr_q;

  always_comb begin
    case (rd_addr)
      A_DAC:   rb_val = dac;
      A_CLR:   rb_val = cc;
      default: rb_val = '0;
    endcase
  end

  wire [FW-1:0] rb_word = rd_pend ? {1'b1, rd_addr, rb_val} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1; sync_q2 <= 1'b1;
      sclk_q <= 1'b0; sclk_q2 <= 1'b0;
      sdin_q <= 1'b0;
      ld_q <= 1'b1; ld_q2 <= 1'b1;
      clr_q <= 1'b1;
      rx <= '0; out_sh <= '0; bit_cnt <= '0;
    end else begin
      sync_q <= sync_n; sync_q2 <= sync_q;
      sclk_q <= sclk;   sclk_q2 <= sclk_q;
      sdin_q <= sdin;
      ld_q <= ld_n;     ld_q2 <= ld_q;
      clr_q <= clr_n;
      if (sclk_fall && !sync_q) begin
        rx     <= {rx[FW-2:0], sdin_q};
        out_sh <= {out_sh[FW-2:0], 1'b0};
        if (bit_cnt != CW'(FW + 1)) bit_cnt <= bit_cnt + CW'(1);
      end
      if (sync_fall) begin
        bit_cnt <= '0;
        out_sh  <= rb_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac <= '0; cc <= '0; inreg <= '0;
      pend <= 1'b0; rd_pend <= 1'b0; rd_addr <= '0;
    end else if (sw_rst) begin
      dac <= '0; cc <= '0; inreg <= '0;
      pend <= 1'b0; rd_pend <= 1'b0; rd_addr <= '0;
    end else begin
      if (frame_ok) begin
        rd_pend <= f_rd;
        if (f_rd) rd_addr <= fa;
      end
      if (wr_cc)  cc    <= fd;
      if (wr_dac) inreg <= fd;
      if (!clr_q || sw_clr) begin
        dac <= cc;
        if (wr_dac) pend <= 1'b1;
      end else if (direct) begin
        dac  <= fd;
        pend <= 1'b0;
      end else if (wr_dac) begin
        pend <= 1'b1;
      end else if (ld_fall && pend) begin
        dac  <= inreg;
        pend <= 1'b0;
      end
    end
  end

  assign dac_code = dac;
  assign sdo      = out_sh[FW-1];
endmodule

module dac_serial_frontend_chk #(
  parameter int DW = 20,
  parameter int FW = 24,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_q,
  input logic          sw_rst,
  input logic          frame_ok,
  input logic          ld_fall,
  input logic          sclk_fall,
  input logic          sync_fall,
  input logic          pend,
  input logic [CW-1:0] bit_cnt,
  input logic [DW-1:0] dac,
  input logic [DW-1:0] cc,
  input logic          sdo
);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FW + 1));

  p_clr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && !sw_rst) |=> (dac == $past(cc)));

  p_clr_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && $past(!clr_q) && $stable(cc) && !sw_rst) |=> $stable(dac));

  p_dac_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac) |-> $past(!clr_q || frame_ok || ld_fall));

  p_pend_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && pend && clr_q && !frame_ok) |=> !pend);

  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall || sync_fall));
endmodule

bind dac_serial_frontend dac_serial_frontend_chk #(.DW(DW), .FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .sw_rst(sw_rst), .frame_ok(frame_ok),
  .ld_fall(ld_fall), .sclk_fall(sclk_fall), .sync_fall(sync_fall), .pend(pend),
  .bit_cnt(bit_cnt), .dac(dac), .cc(cc), .sdo(sdo)
);

// File: tb/dac_serial_frontend_tb.sv
module dac_serial_frontend_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [19:0] dac_code;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [23:0] rxw;
  logic [19:0] cc_m, dac_m;

  always #5 clk = ~clk;

  dac_serial_frontend u_dut (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .sdin(sdin), .ld_n(ld_n), .clr_n(clr_n), .sdo(sdo), .dac_code(dac_code));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] word, input int n, output logic [23:0] got);
    got = '0;
    sync_n = 1'b0; w(3);
    for (int k = 0; k < n; k++) begin
      sdin = (k < 24) ? word[23-k] : 1'b0; w(2);
      sclk = 1'b1; w(3);
      if (k < 24) got[23-k] = sdo;
      sclk = 1'b0; w(3);
    end
    sync_n = 1'b1; w(5);
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    logic [23:0] g;
    frame({1'b0, a, d}, 24, g);
  endtask

  task automatic pulse_ld();
    ld_n = 1'b0; w(4); ld_n = 1'b1; w(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    w(4);
    chk("R8 reset code", {4'h0, dac_code}, 24'h0);
    chk("R9 reset sdo", {23'h0, sdo}, 24'h0);
    rst_n = 1'b1; w(3);

    // R1: synchronous update sweep
    ld_n = 1'b0;
    for (int i = 0; i < 22; i++) begin
      logic [19:0] c;
      c = (i < 20) ? (20'h1 << i) : ((i == 20) ? 20'hFFFFF : 20'h5A5A5);
      wr(3'b001, c);
      chk("R1 sync write", {4'h0, dac_code}, {4'h0, c});
    end
    dac_m = 20'h5A5A5;

    // R2: staged write moved by LDAC edge
    ld_n = 1'b1; w(3);
    for (int i = 0; i < 8; i++) begin
      logic [19:0] c;
      c = 20'h13579 * (i + 3);
      wr(3'b001, c);
      chk("R2 staged hold", {4'h0, dac_code}, {4'h0, dac_m});
      pulse_ld();
      chk("R2 ldac load", {4'h0, dac_code}, {4'h0, c});
      dac_m = c;
    end

    // R3: wrong-length frames discarded
    ld_n = 1'b0; w(3);
    for (int n = 0; n <= 30; n++) begin
      if (n != 24) begin
        frame({4'b0001, 20'h12345}, n, rxw);
        chk("R3 short/long frame", {4'h0, dac_code}, {4'h0, dac_m});
      end
    end
    ld_n = 1'b1; w(3);

    // R4/R5: clear pin behaviour over several clear codes
    for (int i = 0; i < 4; i++) begin
      logic [19:0] d;
      cc_m = 20'hA0000 + 20'h01111 * i;
      d    = 20'h0F0F0 + i;
      wr(3'b011, cc_m);
      chk("R4 cc write no output", {4'h0, dac_code}, {4'h0, dac_m});
      clr_n = 1'b0; w(4);
      chk("R4 clear applied", {4'h0, dac_code}, {4'h0, cc_m});
      ld_n = 1'b0; w(3);
      wr(3'b001, d);
      chk("R5 write blocked", {4'h0, dac_code}, {4'h0, cc_m});
      ld_n = 1'b1; w(3);
      pulse_ld();
      chk("R5 ldac blocked", {4'h0, dac_code}, {4'h0, cc_m});
      clr_n = 1'b1; w(6);
      chk("R5 hold after release", {4'h0, dac_code}, {4'h0, cc_m});
      pulse_ld();
      chk("R5 staged after release", {4'h0, dac_code}, {4'h0, d});
      dac_m = d;
    end

    // R6: software clear
    wr(3'b010, 20'h00002);
    chk("R6 soft clear", {4'h0, dac_code}, {4'h0, cc_m});
    dac_m = cc_m;
    ld_n = 1'b0; w(3);
    wr(3'b001, 20'h3C3C3);
    dac_m = 20'h3C3C3;
    ld_n = 1'b1; w(3);

    // R9: readback
    frame({4'b1001, 20'h0}, 24, rxw);
    frame(24'h0, 24, rxw);
    chk("R9 read dac", rxw, {4'b1001, dac_m});
    frame({4'b1011, 20'h0}, 24, rxw);
    frame(24'h0, 24, rxw);
    chk("R9 read clearcode", rxw, {4'b1011, cc_m});
    frame({4'b1010, 20'hFFFFF}, 24, rxw);
    frame(24'h0, 24, rxw);
    chk("R9 read control", rxw, 24'hA00000);
    frame(24'h0, 24, rxw);
    chk("R9 no selection", rxw, 24'h0);

    // R7: software reset
    wr(3'b010, 20'h00001);
    chk("R7 soft reset code", {4'h0, dac_code}, 24'h0);
    frame({4'b1011, 20'h0}, 24, rxw);
    frame(24'h0, 24, rxw);
    chk("R7 soft reset clearcode", rxw, 24'hB00000);
    pulse_ld();
    chk("R7 staged cleared", {4'h0, dac_code}, 24'h0);

    // R8: reset pin
    ld_n = 1'b0; w(3);
    wr(3'b001, 20'h77777);
    chk("R8 preload", {4'h0, dac_code}, 24'h077777);
    rst_n = 1'b0; w(3);
    chk("R8 held in reset", {4'h0, dac_code}, 24'h0);
    frame({4'b0001, 20'h44444}, 24, rxw);
    chk("R8 ignores frame", {4'h0, dac_code}, 24'h0);
    rst_n = 1'b1; w(4);
    chk("R8 after release", {4'h0, dac_code}, 24'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule